// File: doc/BRIEF.md
# Signedness-Selectable Four-Bit Comparator

This block orders two 4-bit operands and raises exactly one of three flags: the first operand above, equal to, or below the second. A single mode input picks how both bit patterns are read. With mode low they are plain unsigned numbers from 0 to 15. With mode high they are two's complement numbers from -8 to 7. The same pair of patterns can therefore swap order when the mode changes. For example, a pattern with its top bit set is large as an unsigned number but negative as a signed one.

The block is purely combinational, with no clock, no reset and no stored state. The house-style state machine has no place here. Inside, a mode stage adjusts the top bit of each operand: in signed mode it inverts that bit, which maps the signed range onto the unsigned order. A chain of per-bit slices, built by generate, then combines the bits from the least significant position upward into a single greater or equal result. The less-than flag is whatever remains.

Top module: `ordcmp_top`

## Requirements
- R1: `a_eq` is 1 exactly when all four bits of `op_a` equal the four bits of `op_b`, in either mode.
- R2: With `signed_mode` = 0, `a_gt` is 1 exactly when `op_a` > `op_b` read as unsigned values 0..15, and `a_lt` is 1 exactly when `op_a` < `op_b`.
- R3: With `signed_mode` = 1, `a_gt` and `a_lt` follow the comparison of `op_a` and `op_b` read as two's complement values -8..7, where bit 3 is the sign bit.
- R4: For every input combination, exactly one of `a_gt`, `a_eq` and `a_lt` is 1.
- R5: With `signed_mode` = 1 and bit 3 differing between the operands, the operand whose bit 3 is 0 is the greater one, whatever bits 2..0 hold.
- R6: `op_a` = 4'b1000 and `op_b` = 4'b0111 give `a_gt` = 1 with `signed_mode` = 0, and give `a_lt` = 1 with `signed_mode` = 1.
- R7: Changing `signed_mode` has no effect on `a_eq` for any fixed pair of operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| signed_mode | input | 1 | 0: unsigned reading, 1: two's complement reading |
| a_gt | output | 1 | op_a is greater than op_b |
| a_eq | output | 1 | op_a equals op_b |
| a_lt | output | 1 | op_a is less than op_b |

## Verification
The block holds no state, so any fault shows at the flags during the same evaluation as the inputs that expose it. A fault in the sign-bit adjustment shows only when the top bits of the two operands differ. The flags then come out reversed in one mode but stay correct in the other. A fault in a slice or in the carry of the chain shows only for operand pairs whose first differing bit, scanning down from bit 3, lies at that position. The bench therefore runs every pair of operands in both modes.

// File: rtl/ordcmp_pkg.sv
package ordcmp_pkg;
    localparam int unsigned OPND_W = 4;

    typedef struct packed {
        logic gt;
        logic eq;
    } cmp_res_t;
endpackage

// File: rtl/ordcmp_bit_slice.sv
module ordcmp_bit_slice
    import ordcmp_pkg::*;
(
    input  logic     bit_a,
    input  logic     bit_b,
    input  cmp_res_t lower_res,
    output cmp_res_t upper_res
);
    logic bit_gt;
    logic bit_eq;

    always_comb begin
        bit_gt       = bit_a & ~bit_b;
        bit_eq       = ~(bit_a ^ bit_b);
        upper_res.gt = bit_gt | (bit_eq & lower_res.gt);
        upper_res.eq = bit_eq & lower_res.eq;
    end
endmodule

// File: rtl/ordcmp_chain.sv
module ordcmp_chain
    import ordcmp_pkg::*;
#(
    parameter int unsigned WIDTH = OPND_W
) (
    input  logic [WIDTH-1:0] vec_a,
    input  logic [WIDTH-1:0] vec_b,
    output cmp_res_t         res
);
    cmp_res_t stage [0:WIDTH];

    assign stage[0] = '{gt: 1'b0, eq: 1'b1};

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        ordcmp_bit_slice u_slice (
            .bit_a    (vec_a[i]),
            .bit_b    (vec_b[i]),
            .lower_res(stage[i]),
            .upper_res(stage[i+1])
        );
    end

    assign res = stage[WIDTH];

    always_comb begin
        if (!$isunknown({vec_a, vec_b})) begin
            p_chain_unsigned_r2: assert (res.gt == (vec_a > vec_b))
                else $error("chain gt disagrees with unsigned order");
        end
    end
endmodule

// File: rtl/ordcmp_mode_adj.sv
module ordcmp_mode_adj
    import ordcmp_pkg::*;
#(
    parameter int unsigned WIDTH = OPND_W
) (
    input  logic [WIDTH-1:0] raw_in,
    input  logic             signed_mode,
    output logic [WIDTH-1:0] ord_out
);
    localparam int unsigned MSB = WIDTH - 1;

    always_comb begin
        ord_out      = raw_in;
        ord_out[MSB] = raw_in[MSB] ^ signed_mode;
    end
endmodule

// File: rtl/ordcmp_top.sv
module ordcmp_top
    import ordcmp_pkg::*;
(
    input  logic [3:0] op_a,
    input  logic [3:0] op_b,
    input  logic       signed_mode,
    output logic       a_gt,
    output logic       a_eq,
    output logic       a_lt
);
    localparam int unsigned W = OPND_W;

    logic [W-1:0] ord_a;
    logic [W-1:0] ord_b;
    cmp_res_t     chain_res;

    ordcmp_mode_adj #(.WIDTH(W)) u_adj_a (
        .raw_in(op_a), .signed_mode(signed_mode), .ord_out(ord_a)
    );
    ordcmp_mode_adj #(.WIDTH(W)) u_adj_b (
        .raw_in(op_b), .signed_mode(signed_mode), .ord_out(ord_b)
    );

    ordcmp_chain #(.WIDTH(W)) u_chain (
        .vec_a(ord_a), .vec_b(ord_b), .res(chain_res)
    );

    always_comb begin
        a_gt = chain_res.gt;
        a_eq = chain_res.eq;
        a_lt = ~(chain_res.gt | chain_res.eq);
    end

    always_comb begin
        if (!$isunknown({op_a, op_b, signed_mode})) begin
            p_eq_bits_r1: assert (a_eq == (op_a == op_b))
                else $error("eq flag wrong");
            p_onehot_r4: assert ($countones({a_gt, a_eq, a_lt}) == 1)
                else $error("flags not one-hot");
            if (!signed_mode) begin
                p_unsigned_r2: assert (a_gt == (op_a > op_b) && a_lt == (op_a < op_b))
                    else $error("unsigned order wrong");
            end else begin
                p_signed_r3: assert (a_gt == ($signed(op_a) > $signed(op_b))
                                     && a_lt == ($signed(op_a) < $signed(op_b)))
                    else $error("signed order wrong");
                if (op_a[3] != op_b[3]) begin
                    p_sign_wins_r5: assert (a_gt == !op_a[3])
                        else $error("sign bit did not decide");
                end
            end
        end
    end
endmodule

// File: tb/ordcmp_tb_top.sv
`timescale 1ns/1ps
module ordcmp_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_a = 4'd0;
    logic [3:0] op_b = 4'd0;
    logic       signed_mode = 1'b0;
    logic       a_gt, a_eq, a_lt;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ordcmp_top dut_i (
        .op_a(op_a), .op_b(op_b), .signed_mode(signed_mode),
        .a_gt(a_gt), .a_eq(a_eq), .a_lt(a_lt)
    );

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%b b=%b m=%b got gt/eq/lt=%b expected %b",
                     req, op_a, op_b, signed_mode, got, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [3:0] a, input logic [3:0] b, input logic m);
        int va, vb;
        va = m ? ((a >= 8) ? int'(a) - 16 : int'(a)) : int'(a);
        vb = m ? ((b >= 8) ? int'(b) - 16 : int'(b)) : int'(b);
        if (va > vb)       return 3'b100;
        else if (va == vb) return 3'b010;
        else               return 3'b001;
    endfunction

    task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic m);
        @(posedge clk);
        op_a = a; op_b = b; signed_mode = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {a_gt, a_eq, a_lt}, 3'b010);

        apply(4'b1000, 4'b0111, 1'b0);
        check("R6 unsigned", {a_gt, a_eq, a_lt}, 3'b100);
        apply(4'b1000, 4'b0111, 1'b1);
        check("R6 signed", {a_gt, a_eq, a_lt}, 3'b001);
        apply(4'b0000, 4'b1111, 1'b1);
        check("R5 zero over minus one", {a_gt, a_eq, a_lt}, 3'b100);
        apply(4'b1111, 4'b0000, 1'b1);
        check("R5 minus one below zero", {a_gt, a_eq, a_lt}, 3'b001);
        apply(4'b1111, 4'b1111, 1'b0);
        check("R1 all ones", {a_gt, a_eq, a_lt}, 3'b010);

        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [2:0] exp;
                    apply(4'(a), 4'(b), 1'(m));
                    exp = model(4'(a), 4'(b), 1'(m));
                    check(m ? "R3 signed order" : "R2 unsigned order", {a_gt, a_eq, a_lt}, exp);
                    check("R4 one-hot", {2'b00, $countones({a_gt, a_eq, a_lt}) == 1}, 3'b001);
                    check("R1 eq", {2'b00, a_eq}, {2'b00, a == b});
                    if (m == 1 && a[3] != b[3])
                        check("R5 sign decides", {2'b00, a_gt}, {2'b00, ~a[3]});
                end
            end
        end

        for (int a = 0; a < 16; a++) begin
            logic e0;
            apply(4'(a), 4'(a ^ 5), 1'b0);
            e0 = a_eq;
            apply(4'(a), 4'(a ^ 5), 1'b1);
            check("R7 mode keeps eq", {2'b00, a_eq}, {2'b00, e0});
            apply(4'(a), 4'(a), 1'b0);
            e0 = a_eq;
            apply(4'(a), 4'(a), 1'b1);
            check("R7 mode keeps eq", {2'b00, a_eq}, {2'b00, e0});
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired got running expected finished");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule